// File: doc/BRIEF.md
# Framed Request Register File

This block is a small bank of registers that is read and written through framed packets on a valid/accept stream. Each input beat carries a data byte together with a start marker and a stop marker. The first beat of a request is a header. Its low nibble holds the opcode, and its markers must match that opcode. The block answers every legal request with a framed response on a second valid/accept stream. The first response beat echoes the opcode, and the last response beat carries the stop marker.

A write is three beats: the header, an address beat and a data beat. A read is two beats: a header with both markers set, then an address beat. A read returns three beats: the opcode echo, the register contents, and a stop beat with zero data. A write returns two beats: the opcode echo, then the stop beat. The block handles one request at a time. Headers that are malformed or carry an unknown opcode are accepted and discarded.

A seven-state controller runs the sequence. Its states are numbered 0 to 6:

| State | Role |
|---|---|
| 0 | Idle, entered at reset and after each response |
| 1 | Header wait |
| 2 | Read address wait, or a one-cycle pass-through after a write |
| 3 | Write address and data capture |
| 4 | Response start beat |
| 5 | Read data beat |
| 6 | Response stop beat |

Top module: `vrf_regfile`

## Requirements
- R1: When reset is released, the block spends one cycle in state 0 with `in_accept` low and then enters state 1 with `in_accept` high. During reset `out_valid` is low, and every register reads back as zero afterwards.
- R2: `in_accept` is high only in state 1, in state 3, and in state 2 during a read. `out_valid` is high only in states 4, 5 and 6, so `in_accept` and `out_valid` are never high together.
- R3: In state 1, an accepted beat with start=1, stop=1 and low nibble 4'h1 is a read header. The controller goes to state 2 and waits there for the address beat.
- R4: In state 1, an accepted beat with start=1, stop=0 and low nibble 4'h2 is a write header. The controller goes to state 3.
- R5: Any other beat accepted in state 1 is discarded, and the controller stays in state 1. This covers unknown opcodes, wrong markers and beats without start. Such a beat leaves all registers unchanged. The stored opcode is always 4'h1 or 4'h2 once the controller has left state 1.
- R6: In a write, the low 4 bits of the first beat after the header select the register. The following beat is stored into that register.
- R7: A read responds with three beats in order: start=1 with data 8'h01; the addressed register; then stop=1 with data 8'h00.
- R8: A write responds with two beats in order: start=1 with data 8'h02, then stop=1 with data 8'h00.
- R9: While `out_valid` is high and `out_accept` is low, `out_data`, `out_first` and `out_last` hold their values into the next cycle.
- R10: A response beat never has start and stop both set. The start marker drops once its beat is accepted.
- R11: When the stop beat is accepted, the controller returns to state 0. `in_accept` is low for exactly one cycle and is then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request beat present |
| in_accept | output | 1 | Block takes the request beat this cycle |
| in_data | input | DATA_W | Request beat payload |
| in_first | input | 1 | Start marker of request beat |
| in_last | input | 1 | Stop marker of request beat |
| out_valid | output | 1 | Response beat present |
| out_accept | input | 1 | Downstream takes the response beat |
| out_data | output | DATA_W | Response beat payload |
| out_first | output | 1 | Start marker of response beat |
| out_last | output | 1 | Stop marker of response beat |

## Verification
The bench uses the default parameters: an 8-bit data path, a 4-bit address (sixteen registers) and a 4-bit opcode field. With these values, addresses 0 and 15 are both reachable, so the reset-zero check can cover the bottom and the top register. The opcode echo fills only the low nibble of a byte, so the zero upper nibble of the echo beat is checked as well. The bench also runs the response stream under a one-in-three accept pattern, which exercises the hold rule on every beat type.

// File: rtl/vrf_pkg.sv
`timescale 1ns/1ps
// Package vrf_pkg: shared controller state type for the framed register file.
// Assumes a 3-bit encoding. The numbering 0..6 is part of the contract.
package vrf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_ADDR = 3'd2,
        ST_WR   = 3'd3,
        ST_HEAD = 3'd4,
        ST_BODY = 3'd5,
        ST_TAIL = 3'd6
    } vrf_state_e;

endpackage

// File: rtl/vrf_regs.sv
`timescale 1ns/1ps
// Module vrf_regs: register array with one write port and one combinational
// read port. Assumes a single writer. A synchronous active-low reset clears
// every entry.
module vrf_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear all entries on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: combinational lookup.
    assign rd_data = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R6

endmodule

// File: rtl/vrf_ctrl.sv
`timescale 1ns/1ps
// Module vrf_ctrl: decodes request headers and captures the address and data
// beats. It then drives the framed response. It expects the upstream to hold a
// beat stable while valid is high and accept is low. It handles one request
// at a time.
module vrf_ctrl
    import vrf_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          ADDR_W = 4,
    parameter int          OP_W   = 4,
    parameter logic [3:0]  RD_OP  = 4'h1,
    parameter logic [3:0]  WR_OP  = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_accept,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_accept,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - OP_W;

    vrf_state_e        state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_seen_q;
    logic              in_fire, out_fire, hdr_rd, hdr_wr, is_read;

    // Header classification from markers and opcode nibble.
    assign hdr_rd   = in_first &&  in_last && (in_data[OP_W-1:0] == OP_W'(RD_OP));
    assign hdr_wr   = in_first && !in_last && (in_data[OP_W-1:0] == OP_W'(WR_OP));
    assign is_read  = (op_q == OP_W'(RD_OP));
    assign in_fire  = in_valid && in_accept;
    assign out_fire = out_valid && out_accept;

    // Input accept: header wait, write capture, and read address wait.
    always_comb begin
        unique case (state_q)
            ST_HDR, ST_WR: in_accept = 1'b1;
            ST_ADDR:       in_accept = is_read;
            default:       in_accept = 1'b0;
        endcase
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_HDR;
            ST_HDR: begin
                if (in_fire && hdr_rd)      state_d = ST_ADDR;
                else if (in_fire && hdr_wr) state_d = ST_WR;
            end
            ST_WR:   if (in_fire && addr_seen_q) state_d = ST_ADDR;
            ST_ADDR: if (!is_read || in_fire)    state_d = ST_HEAD;
            ST_HEAD: if (out_fire) state_d = is_read ? ST_BODY : ST_TAIL;
            ST_BODY: if (out_fire) state_d = ST_TAIL;
            ST_TAIL: if (out_fire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, opcode and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            op_q        <= '0;
            addr_q      <= '0;
            addr_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HDR && in_fire && (hdr_rd || hdr_wr))
                op_q <= in_data[OP_W-1:0];
            if ((state_q == ST_WR && in_fire && !addr_seen_q) ||
                (state_q == ST_ADDR && in_fire))
                addr_q <= in_data[ADDR_W-1:0];
            if (state_q == ST_WR && in_fire)
                addr_seen_q <= !addr_seen_q;
        end
    end

    // Register write strobe on the data beat of a write.
    assign wr_en   = (state_q == ST_WR) && in_fire && addr_seen_q;
    assign wr_addr = addr_q;
    assign wr_data = in_data;
    assign rd_addr = addr_q;

    // Response beat generation.
    always_comb begin
        out_valid = 1'b0;
        out_first = 1'b0;
        out_last  = 1'b0;
        out_data  = '0;
        unique case (state_q)
            ST_HEAD: begin
                out_valid = 1'b1;
                out_first = 1'b1;
                out_data  = {{PAD_W{1'b0}}, op_q};
            end
            ST_BODY: begin
                out_valid = 1'b1;
                out_data  = rd_data;
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= ST_TAIL); // R2
    AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_accept); // R2
    AST_RD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR && in_valid && hdr_rd |=> state_q == ST_ADDR); // R3
    AST_WR_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR && in_valid && hdr_wr |=> state_q == ST_WR); // R4
    AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q > ST_HDR |-> (op_q == OP_W'(RD_OP) || op_q == OP_W'(WR_OP))); // R5
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_accept |=> $stable(out_data) && $stable(out_first) && $stable(out_last)); // R9
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_first && out_last)); // R10
    AST_FIRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        out_first && out_accept |=> !out_first); // R10
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |=> state_q == ST_HDR); // R11

endmodule

// File: rtl/vrf_regfile.sv
`timescale 1ns/1ps
// Module vrf_regfile: top of the framed register file. It joins the request
// controller and the register array. Both streams follow valid/accept rules.
// Reset is synchronous and active low.
module vrf_regfile #(
    parameter int          DATA_W = 8,
    parameter int          ADDR_W = 4,
    parameter int          OP_W   = 4,
    parameter logic [3:0]  RD_OP  = 4'h1,
    parameter logic [3:0]  WR_OP  = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_accept,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_accept,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    vrf_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W),
        .RD_OP(RD_OP), .WR_OP(WR_OP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_accept(in_accept), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_accept(out_accept), .out_data(out_data),
        .out_first(out_first), .out_last(out_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    vrf_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/vrf_regfile_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: transaction tasks queue the expected response beats, and a
// monitor pops and compares each accepted beat.
module vrf_regfile_tb;

    typedef struct packed {
        logic       f;
        logic       l;
        logic [7:0] d;
    } beat_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_accept;
    logic [7:0] in_data = '0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_accept = 1'b0;
    logic [7:0] out_data;
    logic       out_first;
    logic       out_last;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    stall_en = 1'b0;
    beat_t exp_q[$];
    string tag_q[$];
    logic [7:0] model [16];

    vrf_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_accept(in_accept), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_accept(out_accept), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Downstream accept pattern, changed just after each rising edge.
    always @(posedge clk) begin
        cyc++;
        #1 out_accept = stall_en ? (cyc % 3 == 0) : 1'b1;
    end

    // Monitor: port exclusivity, the hold rule, and scoreboard compare.
    beat_t prev_beat;
    bit    prev_stall = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                check(!in_accept, "R2 accept while responding", {31'd0, in_accept}, 32'd0);
                if (prev_stall)
                    check({out_first, out_last, out_data} == prev_beat, "R9 hold under stall",
                          {22'd0, out_first, out_last, out_data}, {22'd0, prev_beat});
                if (out_accept) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected beat", {22'd0, out_first, out_last, out_data}, 32'd0);
                    end else begin
                        beat_t e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_first, out_last, out_data} == e, t,
                              {22'd0, out_first, out_last, out_data}, {22'd0, e});
                    end
                end
            end
            prev_stall = out_valid && !out_accept;
            prev_beat  = {out_first, out_last, out_data};
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic push(input logic f, input logic l, input logic [7:0] d, input string t);
        beat_t b;
        b = '{f: f, l: l, d: d};
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    // Present one request beat and return at the falling edge before it is taken.
    task automatic send(input logic [7:0] d, input logic f, input logic l);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        in_last  = l;
        do @(negedge clk); while (!in_accept);
    endtask

    // Wait for the response to drain, then check the idle gap (R11).
    task automatic finish_txn();
        @(posedge clk);
        #1 in_valid = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        check(!in_accept, "R11 idle gap after stop", {31'd0, in_accept}, 32'd0);
        @(negedge clk);
        check(in_accept, "R11 header wait resumes", {31'd0, in_accept}, 32'd1);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        push(1'b1, 1'b0, 8'h02, "R8 write echo beat");
        push(1'b0, 1'b1, 8'h00, "R8 write stop beat");
        send(8'h02, 1'b1, 1'b0);        // R4 write header
        send({4'h0, a}, 1'b0, 1'b0);    // R6 address beat
        send(d, 1'b0, 1'b1);            // R6 data beat
        model[a] = d;
        finish_txn();
    endtask

    task automatic do_read(input logic [3:0] a, input string t);
        push(1'b1, 1'b0, 8'h01, "R7 read echo beat");
        push(1'b0, 1'b0, model[a], t);
        push(1'b0, 1'b1, 8'h00, "R7 read stop beat");
        send(8'h01, 1'b1, 1'b1);        // R3 read header
        send({4'h0, a}, 1'b0, 1'b0);
        finish_txn();
    endtask

    task automatic drop_beat(input logic [7:0] d, input logic f, input logic l);
        send(d, f, l);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(in_accept && !out_valid, "R5 discarded header", {30'd0, in_accept, out_valid}, 32'd2);
    endtask

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !in_accept, "R1 quiet during reset", {30'd0, out_valid, in_accept}, 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!in_accept, "R1 first cycle idle", {31'd0, in_accept}, 32'd0);
        @(negedge clk);
        check(in_accept, "R1 header wait after idle", {31'd0, in_accept}, 32'd1);

        do_read(4'd0,  "R1 register 0 cleared");
        do_read(4'd15, "R1 register 15 cleared");
        do_write(4'd3,  8'hA5);
        do_write(4'd15, 8'h3C);
        do_read(4'd3,  "R6 R7 read back reg 3");
        do_read(4'd15, "R6 R7 read back reg 15");

        stall_en = 1'b1;
        do_read(4'd3, "R9 read under stall");
        do_write(4'd7, 8'h81);
        do_read(4'd7, "R9 read back under stall");
        stall_en = 1'b0;

        drop_beat(8'h05, 1'b1, 1'b1);   // R5 unknown opcode
        drop_beat(8'h01, 1'b1, 1'b0);   // R5 read code without stop
        drop_beat(8'h02, 1'b1, 1'b1);   // R5 write code with stop
        drop_beat(8'h01, 1'b0, 1'b1);   // R5 no start marker
        drop_beat(8'h37, 1'b0, 1'b0);   // R5 stray beat
        do_read(4'd3, "R5 register 3 untouched");
        do_read(4'd7, "R5 register 7 untouched");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule